// File: doc/BRIEF.md
# ADC Channel Conversion Sequencer

This block walks a programmed list of analog input channel numbers and hands them one at a time to a converter. It talks to the converter only through a start/done handshake. A rising edge on the trigger input begins activity. The run-mode input sets how much one trigger buys:

- a single conversion;
- one pass over the whole list;
- endless passes over the list;
- a fixed-size group of consecutive entries.

The list position persists across triggers, so the single and grouped modes resume where the previous trigger left off.

For every finished conversion the sequencer raises a one-cycle end-of-conversion strobe. When the finished conversion was the final list entry, it also raises an end-of-sequence strobe in the same cycle. A one-cycle stop input abandons whatever is running and parks the list position at entry zero. The list contents, list length and group size are static configuration inputs.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After synchronous reset, conv_start_o, eoc_o and eos_o are low and conv_chan_o shows list entry 0. List entry i occupies chan_list_in[5*i+4:5*i].
- R2: With mode_in = 0 (single), each trigger converts exactly one entry and the position then advances by one. After the last entry (index list_len_in-1) the position wraps to 0.
- R3: With mode_in = 1 (scan), one trigger converts entries 0 through list_len_in-1 once, in order, and then the block goes idle until the next trigger.
- R4: With mode_in = 2 (continuous), one trigger converts the list repeatedly from entry 0 without further triggers, and eos_o pulses on every pass.
- R5: With mode_in = 3 (grouped), each trigger converts group_sz_in consecutive entries. A group that reaches the list end stops there, even if it is short, and the next trigger starts at entry 0.
- R6: conv_start_o and conv_chan_o stay steady until conv_done_i is seen. The following cycle carries a one-cycle eoc_o with conv_start_o low, and only then may the next request begin. eos_o is high exactly in the eoc_o cycle of the last list entry, in every mode.
- R7: Only a rising edge of trig_in counts, so a trigger held high is a single event. A rising edge while a conversion, scan or group is running is ignored.
- R8: A one-cycle stop_in drops conv_start_o by the next cycle, returns the block to idle and sets the list position to 0. It is the only way out of continuous mode.
- R9: Changing mode_in while idle sets the list position to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Trigger level; rising edge starts work |
| stop_in | input | 1 | One-cycle abort |
| mode_in | input | 2 | Run mode: 0 single, 1 scan, 2 continuous, 3 grouped |
| list_len_in | input | 5 | Number of list entries, 1 to 16 |
| group_sz_in | input | 5 | Entries per group in grouped mode, 1 to 16 |
| chan_list_in | input | 80 | Packed channel list, 5 bits per entry |
| conv_start_o | output | 1 | Conversion request to the converter |
| conv_chan_o | output | 5 | Channel number of the current request |
| conv_done_i | input | 1 | Converter completion pulse |
| eoc_o | output | 1 | End-of-conversion strobe |
| eos_o | output | 1 | End-of-sequence strobe |

## Verification
The bench targets several corner cases, each with a visible symptom if the design got it wrong:

- **Wrap in single and grouped modes.** An off-by-one in the last-entry compare would show up as a missing or misplaced end-of-sequence strobe, or as a conversion of a stale entry beyond the list.
- **Short final group.** A list of five with groups of two ends in a group of one. A design that ignored the list end would run past it, and one that ignored the group size would not stop.
- **Trigger held high or repeated mid-scan.** Either would produce extra conversions if edges were not detected or busy triggers were not dropped.
- **Stop during a pending request and during continuous mode.** Either could leave a request hanging or resume from a nonzero position.
- **Mode change while idle.** Without the position reset, the next trigger would restart from a nonzero entry.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int SLOTS = 16;
    localparam int CHW   = 5;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_SCAN   = 2'd1,
        MODE_LOOP   = 2'd2,
        MODE_GROUP  = 2'd3
    } run_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_EOC  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic at_last;
        logic grp_full;
    } pos_flags_t;

    // Decide, at the end-of-conversion cycle, whether the run is over.
    function automatic logic run_ends(input run_mode_e m, input pos_flags_t f);
        case (m)
            MODE_SINGLE: return 1'b1;
            MODE_SCAN:   return f.at_last;
            MODE_LOOP:   return 1'b0;
            default:     return f.at_last | f.grp_full;
        endcase
    endfunction

endpackage

// File: rtl/adc_seq_edge.sv
module adc_seq_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_q;

    // R7: a level held high yields no second event
    a_r7_single_event: assert property (@(posedge clk) disable iff (rst)
        rise_o && lvl_i |=> !rise_o);

endmodule

// File: rtl/adc_seq_ptr.sv
module adc_seq_ptr #(
    parameter int N_SLOTS = 16,
    parameter int PTR_W   = $clog2(N_SLOTS),
    parameter int LEN_W   = PTR_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear_i,
    input  logic                 new_run_i,
    input  logic                 step_i,
    input  logic [LEN_W-1:0]     len_i,
    input  logic [LEN_W-1:0]     grp_i,
    output logic [PTR_W-1:0]     ptr_o,
    output adc_seq_pkg::pos_flags_t flags_o
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(N_SLOTS);

    logic [PTR_W-1:0] ptr_q;
    logic [LEN_W-1:0] gcnt_q;
    logic [LEN_W-1:0] len_eff, grp_eff, gcnt_inc;

    always_comb begin
        len_eff = (len_i == '0) ? LEN_W'(1) : ((len_i > MAX_LEN) ? MAX_LEN : len_i);
        grp_eff = (grp_i == '0) ? LEN_W'(1) : grp_i;
        gcnt_inc = gcnt_q + LEN_W'(1);
        flags_o.at_last  = ({1'b0, ptr_q} == (len_eff - LEN_W'(1)));
        flags_o.grp_full = (gcnt_inc == grp_eff);
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            ptr_q <= '0;
        end else if (step_i) begin
            ptr_q <= flags_o.at_last ? '0 : ptr_q + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i || new_run_i) gcnt_q <= '0;
        else if (step_i)                 gcnt_q <= gcnt_inc;
    end

    assign ptr_o = ptr_q;

    // R8/R9: a clear request always parks the position at entry zero
    a_r8_clear_to_zero: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> ptr_o == '0);

    // R2: a step away from the list end moves exactly one entry forward
    a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
        step_i && !clear_i && !flags_o.at_last |=> ptr_o == $past(ptr_o) + PTR_W'(1));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int N_SLOTS = adc_seq_pkg::SLOTS,
    parameter int CH_W    = adc_seq_pkg::CHW,
    parameter int PTR_W   = $clog2(N_SLOTS),
    parameter int LEN_W   = PTR_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    trig_in,
    input  logic                    stop_in,
    input  logic [1:0]              mode_in,
    input  logic [LEN_W-1:0]        list_len_in,
    input  logic [LEN_W-1:0]        group_sz_in,
    input  logic [N_SLOTS*CH_W-1:0] chan_list_in,
    output logic                    conv_start_o,
    output logic [CH_W-1:0]         conv_chan_o,
    input  logic                    conv_done_i,
    output logic                    eoc_o,
    output logic                    eos_o
);
    import adc_seq_pkg::*;

    logic [CH_W-1:0] slot [N_SLOTS];

    generate
        for (genvar g = 0; g < N_SLOTS; g++) begin : g_unpack
            assign slot[g] = chan_list_in[g*CH_W +: CH_W];
        end
    endgenerate

    seq_state_e state_q, state_n;
    run_mode_e  mode_cur;
    logic [1:0] mode_q;
    logic       rise, clear, new_run, step;
    logic [PTR_W-1:0] ptr;
    pos_flags_t flags;

    assign mode_cur = run_mode_e'(mode_in);

    adc_seq_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (trig_in),
        .rise_o (rise)
    );

    adc_seq_ptr #(
        .N_SLOTS (N_SLOTS),
        .PTR_W   (PTR_W),
        .LEN_W   (LEN_W)
    ) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (clear),
        .new_run_i (new_run),
        .step_i    (step),
        .len_i     (list_len_in),
        .grp_i     (group_sz_in),
        .ptr_o     (ptr),
        .flags_o   (flags)
    );

    always_comb begin
        clear   = stop_in | ((state_q == ST_IDLE) && (mode_in != mode_q));
        new_run = (state_q == ST_IDLE) && rise && !stop_in;
        step    = (state_q == ST_EOC) && !stop_in;
        state_n = state_q;
        case (state_q)
            ST_IDLE: if (new_run) state_n = ST_REQ;
            ST_REQ: begin
                if (stop_in)          state_n = ST_IDLE;
                else if (conv_done_i) state_n = ST_EOC;
            end
            ST_EOC: begin
                if (stop_in || run_ends(mode_cur, flags)) state_n = ST_IDLE;
                else                                      state_n = ST_REQ;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= mode_in;
        end else begin
            state_q <= state_n;
            mode_q  <= mode_in;
        end
    end

    assign conv_start_o = (state_q == ST_REQ);
    assign conv_chan_o  = slot[ptr];
    assign eoc_o        = (state_q == ST_EOC);
    assign eos_o        = (state_q == ST_EOC) && flags.at_last;

    // R6: the request and its channel hold until the converter answers
    a_r6_request_held: assert property (@(posedge clk) disable iff (rst)
        conv_start_o && !conv_done_i && !stop_in |=> conv_start_o && $stable(conv_chan_o));

    // R6: a completion leads to one end-of-conversion cycle without a request
    a_r6_done_to_eoc: assert property (@(posedge clk) disable iff (rst)
        conv_start_o && conv_done_i && !stop_in |=> eoc_o && !conv_start_o);

    // R6: end-of-conversion lasts one cycle
    a_r6_eoc_pulse: assert property (@(posedge clk) disable iff (rst)
        eoc_o |=> !eoc_o);

    // R8: stop ends all activity at once
    a_r8_stop_idles: assert property (@(posedge clk) disable iff (rst)
        stop_in |=> !conv_start_o && !eoc_o);

    // R2: single mode never chains a second request
    a_r2_single_stops: assert property (@(posedge clk) disable iff (rst)
        eoc_o && mode_in == 2'd0 |=> !conv_start_o);

    // R4: continuous mode always chains the next request
    a_r4_loop_chains: assert property (@(posedge clk) disable iff (rst)
        eoc_o && mode_in == 2'd2 && !stop_in |=> conv_start_o);

endmodule

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig = 1'b0;
    logic        stop = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [4:0]  len = 5'd4;
    logic [4:0]  grp = 5'd2;
    logic [79:0] clist;
    logic        conv_start;
    logic [4:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic        eoc, eos;

    int tests = 0;
    int fails = 0;
    int nconv = 0;
    int neoc = 0;
    int lat_cnt = 0;
    logic [4:0] lchan [256];
    logic       leos  [256];

    always #2.5 clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk          (clk),
        .rst          (rst),
        .trig_in      (trig),
        .stop_in      (stop),
        .mode_in      (mode),
        .list_len_in  (len),
        .group_sz_in  (grp),
        .chan_list_in (clist),
        .conv_start_o (conv_start),
        .conv_chan_o  (conv_chan),
        .conv_done_i  (conv_done),
        .eoc_o        (eoc),
        .eos_o        (eos)
    );

    function automatic logic [4:0] ch(input int i);
        return 5'((i * 7 + 3) % 32);
    endfunction

    // Converter model and activity log, all on the falling edge
    always @(negedge clk) begin
        if (eoc) begin
            if (neoc < 256) leos[neoc] = eos;
            neoc = neoc + 1;
        end
        if (conv_start) begin
            if (lat_cnt == LAT - 1) begin
                conv_done = 1'b1;
                if (nconv < 256) lchan[nconv] = conv_chan;
                nconv = nconv + 1;
                lat_cnt = 0;
            end else begin
                conv_done = 1'b0;
                lat_cnt = lat_cnt + 1;
            end
        end else begin
            conv_done = 1'b0;
            lat_cnt = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_trig();
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop = 1'b1;
        @(negedge clk) stop = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk) mode = m;
        idle(2);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1);
        chk(conv_start == 1'b0, "R1 start", int'(conv_start), 0);
        chk(eoc == 1'b0 && eos == 1'b0, "R1 strobes", int'({eoc, eos}), 0);
        chk(conv_chan == ch(0), "R1 channel", int'(conv_chan), int'(ch(0)));
    endtask

    task automatic t_single();
        int base;
        len = 5'd4;
        base = nconv;
        for (int k = 0; k < 5; k++) begin
            pulse_trig();
            idle(10);
        end
        chk(nconv - base == 5, "R2 count", nconv - base, 5);
        for (int k = 0; k < 5; k++) begin
            chk(lchan[base+k] == ch(k % 4), "R2 channel", int'(lchan[base+k]), int'(ch(k % 4)));
            chk(leos[base+k] == (k % 4 == 3), "R2 eos", int'(leos[base+k]), int'(k % 4 == 3));
        end
    endtask

    task automatic t_handshake();
        set_mode(2'd1);
        set_mode(2'd0);
        pulse_trig();
        chk(conv_start && conv_chan == ch(0), "R6 request", int'(conv_chan), int'(ch(0)));
        idle(2);
        chk(conv_start && conv_chan == ch(0), "R6 held", int'(conv_start), 1);
        idle(1);
        chk(eoc && !conv_start, "R6 eoc", int'({eoc, conv_start}), 2);
        idle(1);
        chk(!eoc && !conv_start, "R6 eoc one cycle", int'({eoc, conv_start}), 0);
    endtask

    task automatic t_scan();
        int base;
        set_mode(2'd1);
        len = 5'd3;
        base = nconv;
        pulse_trig();
        idle(25);
        chk(nconv - base == 3, "R3 count", nconv - base, 3);
        pulse_trig();
        idle(25);
        chk(nconv - base == 6, "R3 second pass", nconv - base, 6);
        for (int k = 0; k < 6; k++) begin
            chk(lchan[base+k] == ch(k % 3), "R3 order", int'(lchan[base+k]), int'(ch(k % 3)));
            chk(leos[base+k] == (k % 3 == 2), "R3 eos", int'(leos[base+k]), int'(k % 3 == 2));
        end
    endtask

    task automatic t_loop();
        int base, snap;
        set_mode(2'd2);
        len = 5'd3;
        base = nconv;
        pulse_trig();
        idle(60);
        chk(nconv - base >= 9, "R4 keeps running", nconv - base, 9);
        for (int k = 0; k < 9; k++) begin
            chk(lchan[base+k] == ch(k % 3), "R4 order", int'(lchan[base+k]), int'(ch(k % 3)));
            chk(leos[base+k] == (k % 3 == 2), "R4 eos each pass", int'(leos[base+k]), int'(k % 3 == 2));
        end
        pulse_stop();
        idle(1);
        snap = nconv;
        idle(30);
        chk(nconv == snap, "R8 loop halted", nconv - snap, 0);
        chk(!conv_start, "R8 no request", int'(conv_start), 0);
    endtask

    task automatic t_group();
        int base;
        set_mode(2'd3);
        len = 5'd5;
        grp = 5'd2;
        base = nconv;
        pulse_trig();
        idle(20);
        chk(nconv - base == 2, "R5 first group", nconv - base, 2);
        pulse_trig();
        idle(20);
        chk(nconv - base == 4, "R5 second group", nconv - base, 4);
        pulse_trig();
        idle(20);
        chk(nconv - base == 5, "R5 short group", nconv - base, 5);
        pulse_trig();
        idle(20);
        chk(nconv - base == 7, "R5 wrapped group", nconv - base, 7);
        for (int k = 0; k < 7; k++) begin
            chk(lchan[base+k] == ch(k % 5), "R5 order", int'(lchan[base+k]), int'(ch(k % 5)));
            chk(leos[base+k] == (k == 4), "R5 eos", int'(leos[base+k]), int'(k == 4));
        end
    endtask

    task automatic t_stop_mid();
        int base;
        base = nconv;
        pulse_trig();
        chk(conv_start && conv_chan == ch(2), "R8 pending request", int'(conv_chan), int'(ch(2)));
        pulse_stop();
        chk(!conv_start, "R8 request dropped", int'(conv_start), 0);
        idle(10);
        chk(nconv == base && !eoc, "R8 no completion", nconv - base, 0);
        pulse_trig();
        idle(20);
        chk(nconv - base == 2, "R8 restart count", nconv - base, 2);
        chk(lchan[base] == ch(0) && lchan[base+1] == ch(1), "R8 restart at zero",
            int'(lchan[base]), int'(ch(0)));
    endtask

    task automatic t_mode_change();
        int base;
        set_mode(2'd0);
        len = 5'd4;
        base = nconv;
        pulse_trig();
        idle(10);
        set_mode(2'd1);
        set_mode(2'd0);
        pulse_trig();
        idle(10);
        chk(nconv - base == 2, "R9 count", nconv - base, 2);
        chk(lchan[base+1] == ch(0), "R9 position reset", int'(lchan[base+1]), int'(ch(0)));
    endtask

    task automatic t_trig_rules();
        int base;
        set_mode(2'd1);
        set_mode(2'd0);
        base = nconv;
        @(negedge clk) trig = 1'b1;
        idle(30);
        trig = 1'b0;
        idle(5);
        chk(nconv - base == 1, "R7 held trigger", nconv - base, 1);
        set_mode(2'd1);
        len = 5'd4;
        base = nconv;
        pulse_trig();
        idle(3);
        pulse_trig();
        idle(40);
        chk(nconv - base == 4, "R7 busy trigger ignored", nconv - base, 4);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) clist[i*5 +: 5] = ch(i);
        t_reset();
        t_single();
        t_handshake();
        t_scan();
        t_loop();
        t_group();
        t_stop_mid();
        t_mode_change();
        t_trig_rules();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule